// File: doc/BRIEF.md
# Block Lock Protection Unit

This unit guards the modify operations of a bottom-boot flash array. The array is split into 39 erase blocks. Two small boot blocks come first, then six small parameter blocks, then 31 large main blocks. The unit keeps one lock bit for each block and a single permanent lock bit. It maps a 20-bit word address to a block index and a block kind. From that it decides, in the same cycle, whether a program, erase or lock-change request is allowed or refused.

The decision uses four inputs: the block's lock bit, the permanent lock, the write-protect input and the supply and reset state. The write-protect input acts only on the boot blocks. Once the permanent lock is set, the lock bits can no longer change, and no command can clear the permanent lock. A sequencer drives the strobes that set one block's lock, clear every block lock, or set the permanent lock.

During a full-array erase the sequencer walks the block indices and asks the unit once for each block. The unit also answers reads of the identifier space, which report the per-block lock state, the permanent lock state and two fixed code bytes. Power-on reset loads every lock bit and the permanent lock from parameters, because the nonvolatile storage itself is not modelled.

Top module: `blk_lock_guard`

## Requirements
- R1: The address decodes to a block index and a kind, where `blk_kind` is 0 for boot, 1 for parameter and 2 for main. Words 00000h–01FFFh are boot blocks 0 and 1 (index 0–1), each 4K words. Words 02000h–07FFFh are parameter blocks 0–5 (index 2–7), each 4K words. Main block n covers 32K words from (n+1)×8000h and has index 8+n.
- R2: After power-on reset every lock bit equals `INIT_LOCK` and the permanent lock equals `INIT_PERM`. Both default to 0.
- R3: `op` is 00 for no request, 01 for program, 10 for erase and 11 for lock change. With `op`=00 both `allow` and `deny` are 0. Otherwise exactly one of them is 1. Program and erase are allowed on an unlocked block and denied on a locked block.
- R4: While `wp_n` is 0, program and erase are denied on both boot blocks whatever their lock bits. While `wp_n` is 1, boot blocks follow their lock bits.
- R5: `wp_n` has no effect on parameter or main blocks.
- R6: A `set_lock` strobe sets the lock bit of the addressed block only.
- R7: A `clr_locks` strobe clears every block lock bit. If `set_lock` is strobed in the same cycle, the addressed bit ends set.
- R8: While the permanent lock is set, `set_lock` and `clr_locks` are ignored and lock-change requests (`op`=11) are denied.
- R9: A `set_perm` strobe sets the permanent lock. Once set, it stays set until power-on reset.
- R10: While `pwr_ok` is 0 or `dev_rst` is 1, every request with `op`≠00 is denied and all strobes are ignored.
- R11: `id_data` returns 00B0h at address 00000h and 00E9h at 00001h. At 00003h it returns the permanent lock on bit 0. At any block's base+2 it returns that block's lock bit on bit 0. Every other address returns 0000h.
- R12: `allow`, `deny`, `blk_idx`, `blk_kind` and `id_data` follow their inputs combinationally. A strobe shows in them from the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; loads the initial lock values |
| addr | input | 20 | Word address of the request, strobe or identifier read |
| op | input | 2 | Requested operation: 00 none, 01 program, 10 erase, 11 lock change |
| wp_n | input | 1 | Write protect; low protects both boot blocks |
| pwr_ok | input | 1 | Supply above the lockout level |
| dev_rst | input | 1 | Device reset pin asserted; blocks all modification |
| set_lock | input | 1 | Strobe: set the lock bit of the addressed block |
| clr_locks | input | 1 | Strobe: clear all block lock bits |
| set_perm | input | 1 | Strobe: set the permanent lock |
| blk_idx | output | 6 | Decoded block index |
| blk_kind | output | 2 | Decoded block kind: 0 boot, 1 parameter, 2 main |
| allow | output | 1 | Request permitted |
| deny | output | 1 | Request refused |
| id_data | output | 16 | Identifier-space read data |

## Verification
The embedded properties check five things on every clock:
- the permanent lock never falls and, once set, freezes every lock bit;
- a boot-block program or erase under active write protect is always denied;
- low supply or device reset denies every request and freezes all lock state;
- a permitted clear leaves every lock bit at zero;
- allow and deny are never both high.

The address map itself is shown only by the bench scenarios, through a table of decode vectors. So are the effect of each strobe on exactly the addressed block, the identifier read-back values, and the fact that write protect leaves parameter and main blocks alone.

// File: rtl/blk_lock_guard.sv
module blk_lock_guard #(
  parameter int ADDR_W   = 20,
  parameter int SMALL_AW = 12,
  parameter int MAIN_AW  = 15,
  parameter int N_BOOT   = 2,
  parameter bit INIT_LOCK = 1'b0,
  parameter bit INIT_PERM = 1'b0,
  parameter logic [7:0] ID_MFR = 8'hB0,
  parameter logic [7:0] ID_DEV = 8'hE9,
  localparam int N_SMALL = 1 << (MAIN_AW - SMALL_AW),
  localparam int N_MAIN  = (1 << (ADDR_W - MAIN_AW)) - 1,
  localparam int NBLK    = N_SMALL + N_MAIN,
  localparam int IDX_W   = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op,
  input  logic              wp_n,
  input  logic              pwr_ok,
  input  logic              dev_rst,
  input  logic              set_lock,
  input  logic              clr_locks,
  input  logic              set_perm,
  output logic [IDX_W-1:0]  blk_idx,
  output logic [1:0]        blk_kind,
  output logic              allow,
  output logic              deny,
  output logic [15:0]       id_data
);
  localparam logic [1:0] OP_NONE = 2'b00;
  localparam logic [1:0] OP_PROG = 2'b01;
  localparam logic [1:0] OP_ERAS = 2'b10;
  localparam logic [1:0] OP_LCFG = 2'b11;

  logic [NBLK-1:0] lock_q;
  logic            perm_q;

  logic [ADDR_W-MAIN_AW-1:0]  main_f;
  logic [MAIN_AW-SMALL_AW-1:0] small_f;
  logic [MAIN_AW-1:0]          blk_off;
  logic in_main, is_boot, cur_lock, mod_ok, cfg_ok, guarded;

  assign main_f  = addr[ADDR_W-1:MAIN_AW];
  assign small_f = addr[MAIN_AW-1:SMALL_AW];
  assign in_main = |main_f;
  assign is_boot = !in_main && (int'(small_f) < N_BOOT);

  assign blk_idx  = in_main ? IDX_W'(main_f) + IDX_W'(N_SMALL - 1) : IDX_W'(small_f);
  assign blk_kind = in_main ? 2'd2 : (is_boot ? 2'd0 : 2'd1);
  assign blk_off  = in_main ? addr[MAIN_AW-1:0] : MAIN_AW'(addr[SMALL_AW-1:0]);
  assign cur_lock = lock_q[blk_idx];

  assign mod_ok  = pwr_ok && !dev_rst;
  assign cfg_ok  = mod_ok && !perm_q;
  assign guarded = cur_lock || (is_boot && !wp_n);

  always_comb begin
    case (op)
      OP_PROG, OP_ERAS: allow = mod_ok && !guarded;
      OP_LCFG:          allow = cfg_ok;
      default:          allow = 1'b0;
    endcase
    deny = (op != OP_NONE) && !allow;
  end

  always_comb begin
    id_data = 16'h0000;
    if (addr == ADDR_W'(0))      id_data = {8'h00, ID_MFR};
    else if (addr == ADDR_W'(1)) id_data = {8'h00, ID_DEV};
    else if (addr == ADDR_W'(3)) id_data = {15'b0, perm_q};
    else if (blk_off == MAIN_AW'(2)) id_data = {15'b0, cur_lock};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= {NBLK{INIT_LOCK}};
      perm_q <= INIT_PERM;
    end else begin
      if (cfg_ok && clr_locks) lock_q <= '0;
      if (cfg_ok && set_lock)  lock_q[blk_idx] <= 1'b1;
      if (mod_ok && set_perm)  perm_q <= 1'b1;
    end
  end

  p_perm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  p_locks_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> $stable(lock_q));

  p_wp_boot_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_PROG || op == OP_ERAS) && blk_kind == 2'd0 && !wp_n) |-> deny);

  p_supply_deny_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((op != OP_NONE) && (!pwr_ok || dev_rst)) |-> deny);

  p_supply_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok || dev_rst) |=> ($stable(lock_q) && $stable(perm_q)));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_locks && !set_lock && pwr_ok && !dev_rst && !perm_q) |=> (lock_q == '0));

  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({allow, deny}));
endmodule

// File: tb/blk_lock_guard_bench.sv
module blk_lock_guard_bench;
  localparam int CLK_P = 10;
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {20'h00000, 6'd0,  2'd0}, {20'h00FFF, 6'd0,  2'd0}, {20'h01000, 6'd1,  2'd0},
    {20'h02000, 6'd2,  2'd1}, {20'h04ABC, 6'd4,  2'd1}, {20'h07FFF, 6'd7,  2'd1},
    {20'h08000, 6'd8,  2'd2}, {20'h0FFFF, 6'd8,  2'd2}, {20'h10000, 6'd9,  2'd2},
    {20'hF8000, 6'd38, 2'd2}, {20'hFFFFF, 6'd38, 2'd2}};

  logic clk = 0, rst_n = 0, wp_n = 1, pwr_ok = 1, dev_rst = 0;
  logic set_lock = 0, clr_locks = 0, set_perm = 0;
  logic [19:0] addr = '0;
  logic [1:0]  op = '0;
  logic [5:0]  blk_idx;
  logic [1:0]  blk_kind;
  logic        allow, deny;
  logic [15:0] id_data;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  blk_lock_guard u_blk_lock_guard (
    .clk(clk), .rst_n(rst_n), .addr(addr), .op(op), .wp_n(wp_n), .pwr_ok(pwr_ok),
    .dev_rst(dev_rst), .set_lock(set_lock), .clr_locks(clr_locks), .set_perm(set_perm),
    .blk_idx(blk_idx), .blk_kind(blk_kind), .allow(allow), .deny(deny), .id_data(id_data));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [19:0] a, input logic [1:0] o);
    @(negedge clk);
    addr = a; op = o;
    #1;
  endtask

  task automatic pulse(input logic [19:0] a, input logic s, input logic c, input logic p);
    @(negedge clk);
    addr = a; op = 2'b00; set_lock = s; clr_locks = c; set_perm = p;
    @(negedge clk);
    set_lock = 0; clr_locks = 0; set_perm = 0;
    #1;
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog R12 act=%0d exp=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    drive(20'h00002, 2'b00); check("R2 boot0 lock init", id_data, 0);
    drive(20'hF8002, 2'b00); check("R2 main30 lock init", id_data, 0);
    drive(20'h00003, 2'b00); check("R2 perm init", id_data, 0);
    check("R3 no request allow", allow, 0);
    check("R3 no request deny", deny, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][27:8], 2'b00);
      check("R1 index", blk_idx, VEC[i][7:2]);
      check("R1 kind", blk_kind, VEC[i][1:0]);
    end

    drive(20'h00000, 2'b00); check("R11 code0", id_data, 16'h00B0);
    drive(20'h00001, 2'b00); check("R11 code1", id_data, 16'h00E9);
    drive(20'h00004, 2'b00); check("R11 other", id_data, 0);

    drive(20'h20000, 2'b01); check("R3 program unlocked", allow, 1);
    pulse(20'h20000, 1, 0, 0);
    drive(20'h20002, 2'b00); check("R6 R12 lock readback", id_data, 1);
    drive(20'h20005, 2'b10); check("R3 erase locked", deny, 1);
    drive(20'h28000, 2'b01); check("R6 neighbour unaffected", allow, 1);
    drive(20'h18002, 2'b00); check("R6 lower neighbour", id_data, 0);

    wp_n = 0;
    drive(20'h00100, 2'b01); check("R4 wp boot0 denied", deny, 1);
    drive(20'h01F00, 2'b10); check("R4 wp boot1 denied", deny, 1);
    drive(20'h05000, 2'b01); check("R5 wp param allowed", allow, 1);
    drive(20'h48000, 2'b10); check("R5 wp main allowed", allow, 1);
    drive(20'h20000, 2'b01); check("R5 wp main locked", deny, 1);
    wp_n = 1;
    drive(20'h00100, 2'b01); check("R4 boot0 follows lock", allow, 1);
    pulse(20'h01000, 1, 0, 0);
    drive(20'h01800, 2'b01); check("R4 boot1 locked wp high", deny, 1);
    pulse(20'h03000, 1, 0, 0);
    wp_n = 0;
    drive(20'h03800, 2'b10); check("R5 param lock wp low", deny, 1);
    wp_n = 1;
    drive(20'h03800, 2'b10); check("R5 param lock wp high", deny, 1);

    pulse(20'h00000, 0, 1, 0);
    drive(20'h20002, 2'b00); check("R7 clear main", id_data, 0);
    drive(20'h01002, 2'b00); check("R7 clear boot", id_data, 0);
    drive(20'h01800, 2'b01); check("R7 program after clear", allow, 1);
    pulse(20'h60000, 1, 1, 0);
    drive(20'h60002, 2'b00); check("R7 set wins same cycle", id_data, 1);
    pulse(20'h00000, 0, 1, 0);

    pwr_ok = 0;
    drive(20'h40000, 2'b01); check("R10 low supply program", deny, 1);
    drive(20'h40000, 2'b11); check("R10 low supply lockcfg", deny, 1);
    pulse(20'h40000, 1, 0, 1);
    drive(20'h40002, 2'b00); check("R10 set ignored", id_data, 0);
    drive(20'h00003, 2'b00); check("R10 perm ignored", id_data, 0);
    pwr_ok = 1; dev_rst = 1;
    drive(20'h40000, 2'b10); check("R10 reset erase", deny, 1);
    pulse(20'h40000, 1, 0, 0);
    drive(20'h40002, 2'b00); check("R10 reset set ignored", id_data, 0);
    dev_rst = 0;
    drive(20'h40000, 2'b11); check("R10 lockcfg restored", allow, 1);

    pulse(20'h40000, 1, 0, 0);
    pulse(20'h00000, 0, 0, 1);
    drive(20'h00003, 2'b00); check("R9 perm set", id_data, 1);
    drive(20'h40000, 2'b11); check("R8 lockcfg denied", deny, 1);
    pulse(20'h00000, 0, 1, 0);
    drive(20'h40002, 2'b00); check("R8 clear ignored", id_data, 1);
    pulse(20'h50000, 1, 0, 0);
    drive(20'h50002, 2'b00); check("R8 set ignored", id_data, 0);
    drive(20'h40000, 2'b01); check("R8 locked stays denied", deny, 1);
    drive(20'h50000, 2'b01); check("R8 unlocked stays allowed", allow, 1);
    repeat (20) @(negedge clk);
    pulse(20'h00000, 0, 1, 1);
    drive(20'h00003, 2'b00); check("R9 perm stays set", id_data, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule